// File: doc/BRIEF.md
# Quadword load/store sequencer

This block carries out one 128-bit register load or store as two 64-bit transfers on a plain request/ready memory port. A request gives a base address, a signed 16-bit displacement, a register index, a direction flag and, for stores, the 128-bit register contents. The block adds the base and the sign-extended displacement, clears the four lowest address bits so that the access always covers one whole 16-byte line, and then runs the two halves of that line in a fixed order.

For a load, the two returned doublewords are assembled into one 128-bit result. That result is presented with a one-cycle register write strobe. For a store, the register value is split into its two halves, and each half goes out on its own beat. A load that names register zero still performs both memory reads, but it produces no register write. A store that names register zero writes zeros, because that register always reads as zero.

Top module: `qword_lsu_seq`

## Requirements
- R1: The line address is formed as base plus the 16-bit displacement sign-extended to the address width, taken modulo 2^32.
- R2: The four least-significant bits of that sum are cleared. The first beat uses the cleared address, and the second beat uses the cleared address plus 8.
- R3: Register bits 63:0 belong to the beat at the cleared address, and bits 127:64 belong to the beat at the cleared address plus 8. This holds both for the store data driven on `mem_wdata` and for the load data assembled on `ld_data`.
- R4: The lower beat is always issued before the upper beat. While `mem_ready` is low, `mem_req` stays high and `mem_addr` and `mem_wdata` are held unchanged.
- R5: A load whose register index is 0 runs both beats and pulses `done`, but `rf_we` stays low.
- R6: A store whose register index is 0 writes zero on both beats, whatever value `req_wdata` carries.
- R7: A request is taken only while `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle, and `req_valid` raised while `busy` is high is ignored and causes no memory beat.
- R8: `done` is high for exactly one cycle per operation. For a load to a nonzero register, `rf_we` is high in that same cycle only, with `rf_waddr` equal to the register index and `ld_data` holding the assembled line.
- R9: `mem_we` is 1 on both beats of a store and 0 on both beats of a load. It is never high without `mem_req`, and a store never raises `rf_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start an operation (taken only when idle) |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_base | input | 32 | Base address |
| req_offset | input | 16 | Signed displacement |
| req_reg | input | 5 | Register index (target or source) |
| req_wdata | input | 128 | Register contents for a store |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 64 | Beat write data |
| mem_ready | input | 1 | Memory accepts or completes the beat this cycle |
| mem_rdata | input | 64 | Beat read data, valid with `mem_ready` |
| done | output | 1 | One-cycle completion pulse |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Register write index |
| ld_data | output | 128 | Assembled load result |

## Verification
Random bases and displacements produce effective addresses at every position inside a line. Adding the sign-extended value checks that both beats land on the same line with the correct offset, which separates a correct sign extension from a zero extension or from a missing alignment mask. Directed cases use the most negative and most positive displacements and an address that wraps past 2^32. Memory read data is a function of the beat address, so a swap of the halves or a capture into the wrong half shows up in `ld_data`. The memory model stalls `mem_ready` at random, which tests holding on stalls. Register zero is tried as both a load target and a store source with nonzero data, and extra requests are raised while the block is busy, to show that they start no extra beats.

// File: rtl/qls_pkg.sv
package qls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT0 = 2'd1,
    ST_BEAT1 = 2'd2,
    ST_DONE  = 2'd3
  } qls_state_e;

endpackage

// File: rtl/qls_fsm.sv
module qls_fsm
  import qls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_ready,
  output logic accept,
  output logic mem_req,
  output logic hi_beat,
  output logic beat_done,
  output logic done,
  output logic busy
);

  qls_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_BEAT0;
      ST_BEAT0: if (mem_ready) state_d = ST_BEAT1;
      ST_BEAT1: if (mem_ready) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign mem_req   = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
  assign hi_beat   = (state_q == ST_BEAT1);
  assign beat_done = mem_req && mem_ready;
  assign done      = (state_q == ST_DONE);
  assign busy      = (state_q != ST_IDLE);

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

endmodule

// File: rtl/qls_addr_gen.sv
module qls_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int BEAT_BYTES = 8,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic              hi_sel,
  output logic [ADDR_W-1:0] beat_addr
);

  localparam logic [ADDR_W-1:0] LOW_MASK   = ADDR_W'((1 << ALIGN_BITS) - 1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~LOW_MASK;
  localparam logic [ADDR_W-1:0] HI_STEP    = ADDR_W'(BEAT_BYTES);

  logic [ADDR_W-1:0] sext_off;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] line_d;
  logic [ADDR_W-1:0] line_q;

  assign sext_off = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
  assign eff_addr = base + sext_off;
  assign line_d   = eff_addr & ALIGN_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (capture) line_q <= line_d;
  end

  assign beat_addr = hi_sel ? (line_q + HI_STEP) : line_q;

endmodule

// File: rtl/qls_datapath.sv
module qls_datapath #(
  parameter int BEAT_W = 64,
  parameter int REG_AW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                req_is_store,
  input  logic [REG_AW-1:0]   req_reg,
  input  logic [2*BEAT_W-1:0] req_wdata,
  input  logic                mem_req,
  input  logic                hi_beat,
  input  logic                beat_done,
  input  logic                done,
  input  logic [BEAT_W-1:0]   mem_rdata,
  output logic                mem_we,
  output logic [BEAT_W-1:0]   mem_wdata,
  output logic                rf_we,
  output logic [REG_AW-1:0]   rf_waddr,
  output logic [2*BEAT_W-1:0] ld_data
);

  logic              is_store_q;
  logic [REG_AW-1:0] reg_q;
  logic              reg_is_zero;
  logic [BEAT_W-1:0] st_half_q [2];
  logic [BEAT_W-1:0] ld_half_q [2];

  assign reg_is_zero = (req_reg == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_store_q <= 1'b0;
      reg_q      <= '0;
    end else if (accept) begin
      is_store_q <= req_is_store;
      reg_q      <= req_reg;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic st_en;
    logic ld_en;
    assign st_en = accept;
    assign ld_en = beat_done && (hi_beat == (g == 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_half_q[g] <= '0;
      else if (st_en) st_half_q[g] <= reg_is_zero ? '0 : req_wdata[g*BEAT_W +: BEAT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ld_half_q[g] <= '0;
      else if (ld_en) ld_half_q[g] <= mem_rdata;
    end

    assign ld_data[g*BEAT_W +: BEAT_W] = ld_half_q[g];
  end

  assign mem_wdata = hi_beat ? st_half_q[1] : st_half_q[0];
  assign mem_we    = mem_req && is_store_q;
  assign rf_we     = done && !is_store_q && (reg_q != '0);
  assign rf_waddr  = reg_q;

  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != '0); // R5

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we); // R8

  AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req); // R9

  AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done && !mem_we); // R9

endmodule

// File: rtl/qword_lsu_seq.sv
module qword_lsu_seq #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int BEAT_W = 64,
  parameter int REG_AW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_is_store,
  input  logic [ADDR_W-1:0]   req_base,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [REG_AW-1:0]   req_reg,
  input  logic [2*BEAT_W-1:0] req_wdata,
  output logic                busy,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BEAT_W-1:0]   mem_wdata,
  input  logic                mem_ready,
  input  logic [BEAT_W-1:0]   mem_rdata,
  output logic                done,
  output logic                rf_we,
  output logic [REG_AW-1:0]   rf_waddr,
  output logic [2*BEAT_W-1:0] ld_data
);

  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int ALIGN_BITS = $clog2(2 * BEAT_BYTES);

  logic accept;
  logic hi_beat;
  logic beat_done;

  qls_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mem_ready (mem_ready),
    .accept    (accept),
    .mem_req   (mem_req),
    .hi_beat   (hi_beat),
    .beat_done (beat_done),
    .done      (done),
    .busy      (busy)
  );

  qls_addr_gen #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .BEAT_BYTES (BEAT_BYTES),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (accept),
    .base      (req_base),
    .offset    (req_offset),
    .hi_sel    (hi_beat),
    .beat_addr (mem_addr)
  );

  qls_datapath #(
    .BEAT_W (BEAT_W),
    .REG_AW (REG_AW)
  ) u_data (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .req_is_store (req_is_store),
    .req_reg      (req_reg),
    .req_wdata    (req_wdata),
    .mem_req      (mem_req),
    .hi_beat      (hi_beat),
    .beat_done    (beat_done),
    .done         (done),
    .mem_rdata    (mem_rdata),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .rf_we        (rf_we),
    .rf_waddr     (rf_waddr),
    .ld_data      (ld_data)
  );

  AST_LO_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !hi_beat |-> mem_addr[ALIGN_BITS-1:0] == '0); // R2

  AST_HI_BEAT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && hi_beat |-> mem_addr[ALIGN_BITS-1:0] == ALIGN_BITS'(BEAT_BYTES)); // R2

  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_addr[ALIGN_BITS-1] == 1'b0); // R4

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R4

endmodule

// File: tb/qword_lsu_seq_test.sv
`timescale 1ns/1ps
module qword_lsu_seq_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_is_store;
  logic [31:0]  req_base;
  logic [15:0]  req_offset;
  logic [4:0]   req_reg;
  logic [127:0] req_wdata;
  logic         busy, mem_req, mem_we, done, rf_we;
  logic [31:0]  mem_addr;
  logic [63:0]  mem_wdata;
  logic         mem_ready;
  logic [63:0]  mem_rdata;
  logic [4:0]   rf_waddr;
  logic [127:0] ld_data;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] lg_addr [0:7];
  logic        lg_we   [0:7];
  logic [63:0] lg_wd   [0:7];
  int          lg_n = 0;

  always #4 clk = ~clk;

  qword_lsu_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
    .req_base(req_base), .req_offset(req_offset), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .done(done), .rf_we(rf_we), .rf_waddr(rf_waddr), .ld_data(ld_data)
  );

  function automatic logic [31:0] line_of(input logic [31:0] b, input logic [15:0] o);
    logic [31:0] ea;
    ea = b + {{16{o[15]}}, o};
    return ea & 32'hFFFF_FFF0;
  endfunction

  function automatic logic [63:0] mem_val(input logic [31:0] a);
    return {a ^ 32'hA5C3_0F96, ~a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: decides ready away from the edge and logs beats that complete at the next edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      mem_rdata = '0;
    end else begin
      mem_ready = ($urandom % 4) != 0;
      mem_rdata = mem_val(mem_addr);
      if (mem_req && mem_ready && lg_n < 8) begin
        lg_addr[lg_n] = mem_addr;
        lg_we[lg_n]   = mem_we;
        lg_wd[lg_n]   = mem_wdata;
        lg_n++;
      end
    end
  end

  task automatic run_op(input bit st, input logic [31:0] b, input logic [15:0] o,
                        input logic [4:0] rg, input logic [127:0] wd, input bit poke);
    logic [31:0]  ln;
    logic [127:0] exp_wd;
    int n;
    ln     = line_of(b, o);
    exp_wd = (st && rg == 5'd0) ? 128'd0 : wd;
    @(negedge clk);
    lg_n = 0;
    req_valid = 1'b1; req_is_store = st; req_base = b; req_offset = o;
    req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", 128'(busy), 128'd1);
    if (poke) begin
      req_valid = 1'b1; req_is_store = ~st; req_base = ~b; req_offset = ~o;
      req_reg = rg + 5'd1; req_wdata = ~wd;
    end
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end
    chk(done == 1'b1, "R4 operation completes", 128'(done), 128'd1);
    chk(lg_n == 2, "R7 exactly two beats", 128'(lg_n), 128'd2);
    chk(lg_addr[0] == ln, "R1 R2 low beat address", 128'(lg_addr[0]), 128'(ln));
    chk(lg_addr[1] == ln + 32'd8, "R2 R4 high beat address", 128'(lg_addr[1]), 128'(ln + 32'd8));
    chk(lg_we[0] == st && lg_we[1] == st, "R9 beat direction",
        128'({lg_we[1], lg_we[0]}), 128'({st, st}));
    if (st) begin
      chk(lg_wd[0] == exp_wd[63:0], "R3 R6 low store half", 128'(lg_wd[0]), 128'(exp_wd[63:0]));
      chk(lg_wd[1] == exp_wd[127:64], "R3 R6 high store half", 128'(lg_wd[1]), 128'(exp_wd[127:64]));
      chk(rf_we == 1'b0, "R9 store never writes register", 128'(rf_we), 128'd0);
    end else if (rg == 5'd0) begin
      chk(rf_we == 1'b0, "R5 load to register zero", 128'(rf_we), 128'd0);
    end else begin
      chk(rf_we == 1'b1 && rf_waddr == rg, "R8 write strobe and index",
          128'({rf_we, rf_waddr}), 128'({1'b1, rg}));
      chk(ld_data == {mem_val(ln + 32'd8), mem_val(ln)}, "R3 R8 assembled load",
          ld_data, {mem_val(ln + 32'd8), mem_val(ln)});
    end
    @(negedge clk);
    chk(done == 1'b0 && rf_we == 1'b0, "R8 one-cycle pulse", 128'({done, rf_we}), 128'd0);
    chk(busy == 1'b0, "R7 idle after done", 128'(busy), 128'd0);
    if (poke) begin
      repeat (3) begin
        @(negedge clk);
        chk(mem_req == 1'b0 && busy == 1'b0, "R7 busy-time request ignored",
            128'({mem_req, busy}), 128'd0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_2468));
    rst_n = 1'b0; req_valid = 1'b0; req_is_store = 1'b0; req_base = '0;
    req_offset = '0; req_reg = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk({busy, mem_req, done, rf_we} == 4'b0, "R7 reset state",
        128'({busy, mem_req, done, rf_we}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, mem_req, done, rf_we} == 4'b0, "R8 idle after reset",
        128'({busy, mem_req, done, rf_we}), 128'd0);

    // directed corners
    run_op(1'b0, 32'h0000_1000, 16'h8000, 5'd3, '0, 1'b0);                   // R1 most negative
    run_op(1'b0, 32'h0000_1000, 16'h7FFF, 5'd4, '0, 1'b0);                   // R1 most positive
    run_op(1'b0, 32'hFFFF_FFF8, 16'h0010, 5'd5, '0, 1'b0);                   // R1 wrap
    run_op(1'b1, 32'h2000_0007, 16'h0009, 5'd6,
           128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b0);              // R2 R3
    run_op(1'b0, 32'h3000_0000, 16'h0000, 5'd0, '0, 1'b0);                   // R5
    run_op(1'b1, 32'h3000_0040, 16'hFFF1, 5'd0, {4{32'hDEAD_BEEF}}, 1'b0);   // R6
    run_op(1'b0, 32'h4000_0100, 16'h0004, 5'd9, '0, 1'b1);                   // R7 poke on load
    run_op(1'b1, 32'h4000_0200, 16'h000C, 5'd31, {2{64'hCAFE_F00D_1234_5678}}, 1'b1); // R7 poke on store

    // random mix
    for (int i = 0; i < 60; i++) begin
      run_op(1'($urandom), $urandom, 16'($urandom), 5'($urandom),
             {$urandom, $urandom, $urandom, $urandom}, ($urandom % 5) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule